// File: doc/BRIEF.md
# Link Activation Code Checker

This block sits behind the escape detector of a two-wire debug link. A select escape leaves the link waiting for a control packet. The block then takes the next twelve data-line bits, one on each rising edge of the link clock, and splits them into three four-bit fields: an activation code, an extension code and a check field. Only one exact combination is accepted. When every bit matches, the block switches the link online. From then on, a separate unit treats link traffic as three-bit scan packets, until a reset escape or a deselect escape arrives.

Any other bit combination sends the link back offline and raises a single-cycle abort once the twelfth bit has arrived. A reset or deselect escape during the capture drops the capture at once and raises no abort. The link clock edges and data bits come in as strobes and samples in the system clock domain. Escape detection and scan-packet handling belong to other blocks.

Top module: `actchk_top`

## Requirements
- R1: After reset, activate_o and abort_o are both 0.
- R2: Each field is received least significant bit first. The accepted field values are activation 4'b1100, extension 4'b1000 and check 4'b0000, so the wire order is 0,0,1,1, 0,0,0,1, 0,0,0,0. When all twelve bits match, activate_o is 1 from the clock edge that samples the twelfth strobe.
- R3: activate_o stays 0 while fewer than twelve strobes have been taken. System-clock cycles without line_rise_i do not advance the capture.
- R4: When any of the twelve bits differs from the accepted pattern, activate_o stays 0 and the link returns offline.
- R5: On a mismatch, abort_o is a one-cycle pulse raised at the edge that samples the twelfth strobe, never earlier, even when the first wrong bit came sooner.
- R6: esc_abandon_i during a capture returns the link offline with no abort pulse. Later strobes are then ignored until the next select.
- R7: sel_start_i clears the bit counter and the received bits and starts a fresh capture. A strobe in the same cycle as sel_start_i is not taken.
- R8: While online, activate_o holds at 1 whatever the strobes and bits do. esc_abandon_i clears it at the next edge.
- R9: While offline, strobes and bits have no effect on either output.
- R10: When esc_abandon_i and sel_start_i arrive in the same cycle, esc_abandon_i wins and the link goes offline.
- R11: sel_start_i while online drops activate_o at the next edge and begins a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_start_i | input | 1 | One-cycle strobe: select escape seen |
| esc_abandon_i | input | 1 | One-cycle strobe: reset or deselect escape seen |
| line_rise_i | input | 1 | One-cycle strobe: rising edge of the link clock |
| line_bit_i | input | 1 | Data-line level sampled at that rising edge |
| activate_o | output | 1 | Link online; scan-packet format in force |
| abort_o | output | 1 | One-cycle pulse: control packet rejected |

## Verification
Both outputs are registered. A strobe presented in one system-clock cycle shows up on activate_o or abort_o right after the edge that ends that cycle, with no further delay. The driver sets the inputs on the falling edge. It queues the output pair that the requirements call for after the coming rising edge. The monitor pops and compares that pair two nanoseconds after the rising edge, so each expectation is checked in exactly the cycle its stimulus is due to take effect. Idle cycles are placed between strobes and after each decision. These confirm that the capture does not advance without strobes and that abort lasts exactly one cycle.

// File: rtl/actchk_pkg.sv
package actchk_pkg;
  typedef enum logic [1:0] {
    LS_OFF = 2'd0,
    LS_CAP = 2'd1,
    LS_ON  = 2'd2
  } lstate_e;
endpackage

// File: rtl/actchk_bitcount.sv
module actchk_bitcount #(
  parameter int TOTAL = 12,
  localparam int CW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign last_o = (cnt_q == CW'(TOTAL - 1));
  assign cnt_en = clr_i | adv_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (adv_i && last_o) cnt_d = '0;
    else if (adv_i)           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3: the bit index never runs past the packet length
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TOTAL));

  // R3: the index only moves on a taken strobe or a clear
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/actchk_capture.sv
module actchk_capture #(
  parameter int          TOTAL   = 12,
  parameter logic [TOTAL-1:0] PATTERN = '0,
  localparam int CW = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic [CW-1:0] idx_i,
  output logic          match_o
);
  logic [TOTAL-1:0] sr_q, sr_d;
  logic             miss_q, miss_d;
  logic             exp_bit;
  logic             reg_en;

  // expected bit for the current position, selected over the packet length
  always_comb begin
    exp_bit = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      if (idx_i == CW'(k)) exp_bit = PATTERN[k];
    end
  end

  assign reg_en = clr_i | shift_i;

  always_comb begin
    sr_d   = sr_q;
    miss_d = miss_q;
    if (clr_i) begin
      sr_d   = '0;
      miss_d = 1'b0;
    end else if (shift_i) begin
      sr_d   = {bit_i, sr_q[TOTAL-1:1]};
      miss_d = miss_q | (bit_i != exp_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      miss_q <= 1'b0;
    end else if (reg_en) begin
      sr_q   <= sr_d;
      miss_q <= miss_d;
    end
  end

  // decision for the bit being taken now: no early miss and full word equal
  assign match_o = !miss_d && (sr_d == PATTERN);

  // R7: a new select leaves no trace of the previous capture
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sr_q == '0 && !miss_q));

  // R4: once a wrong bit has been seen no match is reported
  p_miss_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_q && !clr_i) |-> !match_o);
endmodule

// File: rtl/actchk_seq.sv
module actchk_seq
  import actchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abandon_i,
  input  logic rise_i,
  input  logic last_i,
  input  logic match_i,
  output logic clr_o,
  output logic adv_o,
  output logic activate_o,
  output logic abort_o
);
  lstate_e state_q, state_d;
  logic    abort_q, abort_d;

  assign clr_o = start_i & ~abandon_i;
  assign adv_o = (state_q == LS_CAP) & rise_i & ~start_i & ~abandon_i;

  always_comb begin
    state_d = state_q;
    abort_d = 1'b0;
    if (abandon_i) begin
      state_d = LS_OFF;
    end else if (start_i) begin
      state_d = LS_CAP;
    end else begin
      unique case (state_q)
        LS_CAP: begin
          if (rise_i && last_i) begin
            state_d = match_i ? LS_ON : LS_OFF;
            abort_d = !match_i;
          end
        end
        LS_ON:   state_d = LS_ON;
        default: state_d = LS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_OFF;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  assign activate_o = (state_q == LS_ON);
  assign abort_o    = abort_q;

  // R5: abort lasts a single cycle
  p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);

  // R5: abort only follows a strobe on the final bit
  p_abort_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> $past(rise_i && last_i && !match_i));

  // R2: going online follows a matching final strobe
  p_act_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(activate_o) |-> $past(rise_i && last_i && match_i));

  // R8: a reset/deselect escape always takes the link offline
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_i |=> !activate_o);

  // R4: rejection and activation never coincide
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && activate_o));
endmodule

// File: rtl/actchk_top.sv
module actchk_top #(
  parameter int              FIELD_W  = 4,
  parameter logic [FIELD_W-1:0] ACT_CODE = 4'b1100,
  parameter logic [FIELD_W-1:0] EXT_CODE = 4'b1000,
  parameter logic [FIELD_W-1:0] CHK_CODE = 4'b0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_start_i,
  input  logic esc_abandon_i,
  input  logic line_rise_i,
  input  logic line_bit_i,
  output logic activate_o,
  output logic abort_o
);
  localparam int TOTAL = 3 * FIELD_W;
  localparam int CW    = $clog2(TOTAL);
  // first received bit lands in bit 0, so fields stack from the low end
  localparam logic [TOTAL-1:0] PATTERN = {CHK_CODE, EXT_CODE, ACT_CODE};

  logic          clr, adv, last, match;
  logic [CW-1:0] idx;

  actchk_bitcount #(.TOTAL(TOTAL)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .adv_i  (adv),
    .cnt_o  (idx),
    .last_o (last)
  );

  actchk_capture #(.TOTAL(TOTAL), .PATTERN(PATTERN)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .shift_i (adv),
    .bit_i   (line_bit_i),
    .idx_i   (idx),
    .match_o (match)
  );

  actchk_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (sel_start_i),
    .abandon_i  (esc_abandon_i),
    .rise_i     (line_rise_i),
    .last_i     (last),
    .match_i    (match),
    .clr_o      (clr),
    .adv_o      (adv),
    .activate_o (activate_o),
    .abort_o    (abort_o)
  );

  // R9: offline strobes never bring the link online
  p_offline_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!activate_o && !sel_start_i && !adv) |=> !activate_o);
endmodule

// File: tb/actchk_top_tb_top.sv
module actchk_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic sel_start_i, esc_abandon_i, line_rise_i, line_bit_i;
  logic activate_o, abort_o;

  always #5 clk = ~clk;

  actchk_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_start_i   (sel_start_i),
    .esc_abandon_i (esc_abandon_i),
    .line_rise_i   (line_rise_i),
    .line_bit_i    (line_bit_i),
    .activate_o    (activate_o),
    .abort_o       (abort_o)
  );

  localparam logic [11:0] GOOD = 12'h08C; // wire order bit0 first

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  bit [1:0] q_exp[$];
  string    q_tag[$];

  // monitor: one expectation per driven cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        bit [1:0] e;
        string    t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if ({activate_o, abort_o} !== e) begin
          n_err++;
          $display("FAIL %s: act/abort=%b%b expected %b%b", t,
                   activate_o, abort_o, e[1], e[0]);
        end
      end
    end
  end

  task automatic step(input bit s, input bit a, input bit r, input bit b,
                      input bit ea, input bit eb, input string tag);
    @(negedge clk);
    sel_start_i   = s;
    esc_abandon_i = a;
    line_rise_i   = r;
    line_bit_i    = b;
    q_exp.push_back({ea, eb});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input bit ea, input string tag);
    step(0, 0, 0, 0, ea, 0, tag);
  endtask

  // send twelve bits with an idle gap after each; ok selects the outcome
  task automatic send(input logic [11:0] w, input bit ok, input string tag);
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 1, w[i], (i == 11) && ok, (i == 11) && !ok, tag);
      if (i < 11) idle(0, tag);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    sel_start_i = 0; esc_abandon_i = 0; line_rise_i = 0; line_bit_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    idle(0, "R1 reset state");
    idle(0, "R1 reset state");

    // offline traffic is ignored
    for (int i = 0; i < 12; i++) step(0, 0, 1, GOOD[i], 0, 0, "R9 offline strobe");

    // good packet with gaps between strobes
    step(1, 0, 0, 0, 0, 0, "R7 start");
    send(GOOD, 1, "R2 R3 good packet");
    idle(1, "R8 online hold");
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[0], 1, 0, "R8 strobes while online");
    step(0, 1, 0, 0, 0, 0, "R8 abandon drops");
    idle(0, "R8 stays offline");

    // single-bit errors at several positions
    for (int p = 0; p < 12; p += 5) begin
      step(1, 0, 0, 0, 0, 0, "R7 start");
      send(GOOD ^ (12'h1 << p), 0, "R4 R5 mismatch");
      idle(0, "R5 abort is one cycle");
    end
    step(1, 0, 0, 0, 0, 0, "R7 start");
    send(12'hFFF, 0, "R4 all ones");
    idle(0, "R5 abort is one cycle");

    // abandon mid-capture, then the rest of the bits
    step(1, 0, 0, 0, 0, 0, "R7 start");
    for (int i = 0; i < 5; i++) step(0, 0, 1, GOOD[i], 0, 0, "R6 partial");
    step(0, 1, 0, 0, 0, 0, "R6 abandon");
    for (int i = 0; i < 12; i++) step(0, 0, 1, GOOD[i], 0, 0, "R6 ignored after abandon");

    // restart during capture; strobe together with start is not taken
    step(1, 0, 0, 0, 0, 0, "R7 start");
    for (int i = 0; i < 6; i++) step(0, 0, 1, GOOD[i], 0, 0, "R7 partial");
    step(1, 0, 1, 1, 0, 0, "R7 restart with strobe");
    send(GOOD, 1, "R7 fresh capture");

    // start while online
    step(1, 0, 0, 0, 0, 0, "R11 start while online");
    send(GOOD ^ 12'h800, 0, "R11 new capture rejected");

    // abandon beats start in the same cycle
    step(1, 0, 0, 0, 0, 0, "R7 start");
    for (int i = 0; i < 3; i++) step(0, 0, 1, GOOD[i], 0, 0, "R10 partial");
    step(1, 1, 0, 0, 0, 0, "R10 abandon and start");
    for (int i = 0; i < 12; i++) step(0, 0, 1, GOOD[i], 0, 0, "R10 offline wins");
    idle(0, "R10 offline wins");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<20000", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule